// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Port

This block is the configuration front end of a multi-function peripheral chip, seen by the host as two byte-wide I/O locations at adjacent addresses. The lower address is the index port and the next one is the data port. After reset the configuration space is sealed. A fixed four-byte key, written byte by byte to the index port, opens it. While it is open, the host puts a register number in the index port and then reads or writes that register through the data port. The host closes the space again with a dedicated exit write.

The register space has two parts. Indices below 0x30 are global: a logical-device selector, a read-only chip identity word and a revision byte. Indices from 0x30 upward form a bank that belongs to whichever logical device is selected. Only the GPIO device (device number 0x07) is implemented. Its bank holds a 16-bit base address for an 8-byte simple-I/O window and three groups of per-pin control bytes: polarity, pin-function select and output enable. These bytes drive the GPIO pin logic through the block's outputs.

Top module: `cfg_port_top`

## Requirements
- R1: Reset leaves the space locked, the read data at 0xFF, the selected logical device at 0, and the base address, polarity, select and output-enable bytes all at zero.
- R2: Writing 0x87, 0x01, 0x55, 0x55 to the index port (address 0x002E), in that order, raises `cfg_open` in the cycle after the fourth write. The index then reads 0x00.
- R3: A byte that breaks the key sequence sends matching back to the start. If that byte is 0x87, it counts as the first key byte, so 0x87 0x01 0x87 0x01 0x55 0x55 unlocks and 0x87 0x01 0x33 0x55 0x55 does not.
- R4: While locked, writes to the data port (0x002F) have no effect, and reads of either port return 0xFF.
- R5: `bus_rdata` is registered. It takes the new value at the clock edge that samples `bus_rd`, and it holds that value until the next read.
- R6: Index 0x20 reads 0x87, index 0x21 reads 0x28 (identity word 0x8728, high byte first), and index 0x22 reads the revision parameter in bits 3:0 with bits 7:4 zero. All three ignore writes.
- R7: Index 0x07 is the logical-device selector and can be read and written. Indices 0x30 and above reach the GPIO bank only when the selector holds 0x07. With any other value they read 0x00 and ignore writes.
- R8: GPIO indices 0x62 (high byte) and 0x63 (low byte) hold `gpio_base`. Bits 2:0 of the low byte are forced to zero, so the 8-byte window stays aligned.
- R9: GPIO indices 0xB0+g, 0xC0+g (g below 5) and 0xC8+g (g below 8) drive bits 8g+7:8g of `gpio_pol`, `gpio_sel` and `gpio_oe` respectively, and read back what was written.
- R10: An unimplemented index reads 0x00 and ignores writes.
- R11: Writing 0x02 through the data port while the index is 0x02 locks the space from the next cycle. Any other value written there leaves it open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Host I/O address |
| bus_wdata | input | 8 | Host write byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read byte |
| cfg_open | output | 1 | Configuration space unlocked |
| gpio_base | output | 16 | GPIO simple-I/O window base address |
| gpio_pol | output | 40 | Polarity bytes, one per group |
| gpio_sel | output | 40 | Pin-function select bytes, one per group |
| gpio_oe | output | 64 | Output-enable bytes, one per group |

## Verification
Every write, whether a key byte, an index, a register or an exit, takes effect at the clock edge that samples the strobe. Its result, such as `cfg_open`, a GPIO output or a later read, is visible from the following cycle. Read data lands in `bus_rdata` at the edge that samples `bus_rd`. The bench drives each strobe for one cycle from the falling edge and samples on the next falling edge, which is half a cycle after the result is due. For R5 it also samples shortly after raising `bus_rd`, before any edge, to confirm the old value still holds. Reset is released through a two-stage synchronizer, so the bench waits several cycles before its first access.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam logic [15:0] IDX_PORT_ADDR  = 16'h002E;
  localparam logic [15:0] DATA_PORT_ADDR = 16'h002F;

  localparam logic [7:0] KEY_B0 = 8'h87;
  localparam logic [7:0] KEY_B1 = 8'h01;
  localparam logic [7:0] KEY_B2 = 8'h55;
  localparam logic [7:0] KEY_B3 = 8'h55;

  localparam logic [7:0] IDX_EXIT   = 8'h02;
  localparam logic [7:0] EXIT_VALUE = 8'h02;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_ID_HI  = 8'h20;
  localparam logic [7:0] IDX_ID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV    = 8'h22;
  localparam logic [7:0] DEV_SPACE  = 8'h30;

  localparam logic [15:0] CHIP_ID   = 16'h8728;
  localparam logic [7:0]  LDN_GPIO  = 8'h07;

  localparam logic [7:0] IDX_BASE_HI = 8'h62;
  localparam logic [7:0] IDX_BASE_LO = 8'h63;
  localparam logic [7:0] IDX_PS_BASE = 8'hB0;
  localparam logic [7:0] IDX_SE_BASE = 8'hC0;
  localparam logic [7:0] IDX_OE_BASE = 8'hC8;

  localparam int          WIN_BYTES  = 8;
  localparam logic [7:0]  BASE_MASK  = ~8'(WIN_BYTES - 1);

  typedef enum logic [2:0] {
    UL_IDLE,
    UL_K1,
    UL_K2,
    UL_K3,
    UL_OPEN
  } unlock_state_e;

  function automatic logic [7:0] expected_key(input unlock_state_e st);
    case (st)
      UL_IDLE: expected_key = KEY_B0;
      UL_K1:   expected_key = KEY_B1;
      UL_K2:   expected_key = KEY_B2;
      default: expected_key = KEY_B3;
    endcase
  endfunction

  function automatic unlock_state_e advance(input unlock_state_e st);
    case (st)
      UL_IDLE: advance = UL_K1;
      UL_K1:   advance = UL_K2;
      UL_K2:   advance = UL_K3;
      default: advance = UL_OPEN;
    endcase
  endfunction

endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wr_byte,
  input  logic       exit_req,
  output logic       open
);

  unlock_state_e state_q;
  unlock_state_e state_d;

  // Next state: sequential key match; a mismatch restarts, re-seeding on KEY_B0.
  always_comb begin
    state_d = state_q;
    if (state_q == UL_OPEN) begin
      if (exit_req) begin
        state_d = UL_IDLE;
      end
    end else if (idx_wr) begin
      if (wr_byte == expected_key(state_q)) begin
        state_d = advance(state_q);
      end else if (wr_byte == KEY_B0) begin
        state_d = UL_K1;
      end else begin
        state_d = UL_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UL_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign open = (state_q == UL_OPEN);

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter logic [3:0] CHIP_REV = 4'h3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wr_byte,
  output logic [7:0] cur_idx,
  output logic [7:0] cur_ldn,
  output logic       in_dev_space,
  output logic [7:0] rd_byte
);

  logic [7:0] idx_q, idx_d;
  logic       idx_en;
  logic [7:0] ldn_q;
  logic       ldn_en;

  // Index loads only while open and is cleared whenever the space is locked.
  always_comb begin
    idx_en = 1'b0;
    idx_d  = idx_q;
    if (open) begin
      idx_en = idx_wr;
      idx_d  = wr_byte;
    end else if (idx_q != 8'h00) begin
      idx_en = 1'b1;
      idx_d  = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign ldn_en = data_wr && (idx_q == IDX_LDN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldn_q <= 8'h00;
    end else if (ldn_en) begin
      ldn_q <= wr_byte;
    end
  end

  always_comb begin
    case (idx_q)
      IDX_LDN:   rd_byte = ldn_q;
      IDX_ID_HI: rd_byte = CHIP_ID[15:8];
      IDX_ID_LO: rd_byte = CHIP_ID[7:0];
      IDX_REV:   rd_byte = {4'h0, CHIP_REV};
      default:   rd_byte = 8'h00;
    endcase
  end

  assign cur_idx      = idx_q;
  assign cur_ldn      = ldn_q;
  assign in_dev_space = (idx_q >= DEV_SPACE);

endmodule

// File: rtl/cfg_gpio_bank.sv
module cfg_gpio_bank
  import cfg_port_pkg::*;
#(
  parameter int NUM_PS_GRP = 5,
  parameter int NUM_SE_GRP = 5,
  parameter int NUM_OE_GRP = 8,
  localparam int PS_W = 8 * NUM_PS_GRP,
  localparam int SE_W = 8 * NUM_SE_GRP,
  localparam int OE_W = 8 * NUM_OE_GRP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      cur_idx,
  input  logic [7:0]      wr_byte,
  output logic [7:0]      rd_byte,
  output logic [15:0]     gpio_base,
  output logic [PS_W-1:0] gpio_pol,
  output logic [SE_W-1:0] gpio_sel,
  output logic [OE_W-1:0] gpio_oe
);

  logic [7:0] base_hi_q, base_lo_q;
  logic       base_hi_en, base_lo_en;

  assign base_hi_en = wr_en && (cur_idx == IDX_BASE_HI);
  assign base_lo_en = wr_en && (cur_idx == IDX_BASE_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi_q <= 8'h00;
    end else if (base_hi_en) begin
      base_hi_q <= wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= 8'h00;
    end else if (base_lo_en) begin
      base_lo_q <= wr_byte & BASE_MASK;
    end
  end

  assign gpio_base = {base_hi_q, base_lo_q};

  logic [7:0] ps_q [NUM_PS_GRP];
  logic [7:0] se_q [NUM_SE_GRP];
  logic [7:0] oe_q [NUM_OE_GRP];

  for (genvar g = 0; g < NUM_PS_GRP; g++) begin : g_ps
    logic en;
    assign en = wr_en && (cur_idx == IDX_PS_BASE + 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ps_q[g] <= 8'h00;
      end else if (en) begin
        ps_q[g] <= wr_byte;
      end
    end
    assign gpio_pol[8*g +: 8] = ps_q[g];
  end

  for (genvar g = 0; g < NUM_SE_GRP; g++) begin : g_se
    logic en;
    assign en = wr_en && (cur_idx == IDX_SE_BASE + 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        se_q[g] <= 8'h00;
      end else if (en) begin
        se_q[g] <= wr_byte;
      end
    end
    assign gpio_sel[8*g +: 8] = se_q[g];
  end

  for (genvar g = 0; g < NUM_OE_GRP; g++) begin : g_oe
    logic en;
    assign en = wr_en && (cur_idx == IDX_OE_BASE + 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oe_q[g] <= 8'h00;
      end else if (en) begin
        oe_q[g] <= wr_byte;
      end
    end
    assign gpio_oe[8*g +: 8] = oe_q[g];
  end

  always_comb begin
    rd_byte = 8'h00;
    if (cur_idx == IDX_BASE_HI) rd_byte = base_hi_q;
    if (cur_idx == IDX_BASE_LO) rd_byte = base_lo_q;
    for (int g = 0; g < NUM_PS_GRP; g++) begin
      if (cur_idx == IDX_PS_BASE + 8'(g)) rd_byte = ps_q[g];
    end
    for (int g = 0; g < NUM_SE_GRP; g++) begin
      if (cur_idx == IDX_SE_BASE + 8'(g)) rd_byte = se_q[g];
    end
    for (int g = 0; g < NUM_OE_GRP; g++) begin
      if (cur_idx == IDX_OE_BASE + 8'(g)) rd_byte = oe_q[g];
    end
  end

endmodule

// File: rtl/cfg_port_top.sv
module cfg_port_top
  import cfg_port_pkg::*;
#(
  parameter int         NUM_PS_GRP = 5,
  parameter int         NUM_SE_GRP = 5,
  parameter int         NUM_OE_GRP = 8,
  parameter logic [3:0] CHIP_REV   = 4'h3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             bus_addr,
  input  logic [7:0]              bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [7:0]              bus_rdata,
  output logic                    cfg_open,
  output logic [15:0]             gpio_base,
  output logic [8*NUM_PS_GRP-1:0] gpio_pol,
  output logic [8*NUM_SE_GRP-1:0] gpio_sel,
  output logic [8*NUM_OE_GRP-1:0] gpio_oe
);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_i = rst_pipe[1];

  logic       hit_idx, hit_data;
  logic       idx_wr, data_wr, exit_req;
  logic [7:0] cur_idx, cur_ldn;
  logic       dev_sel, gpio_sel_ldn;
  logic [7:0] glob_rd, gpio_rd, reg_rd;

  assign hit_idx      = (bus_addr == IDX_PORT_ADDR);
  assign hit_data     = (bus_addr == DATA_PORT_ADDR);
  assign idx_wr       = bus_wr && hit_idx;
  assign data_wr      = bus_wr && hit_data && cfg_open;
  assign exit_req     = data_wr && (cur_idx == IDX_EXIT) && (bus_wdata == EXIT_VALUE);
  assign gpio_sel_ldn = (cur_ldn == LDN_GPIO);

  cfg_unlock_fsm u_unlock (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .idx_wr   (idx_wr),
    .wr_byte  (bus_wdata),
    .exit_req (exit_req),
    .open     (cfg_open)
  );

  cfg_global_regs #(
    .CHIP_REV (CHIP_REV)
  ) u_glob (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .open         (cfg_open),
    .idx_wr       (idx_wr),
    .data_wr      (data_wr),
    .wr_byte      (bus_wdata),
    .cur_idx      (cur_idx),
    .cur_ldn      (cur_ldn),
    .in_dev_space (dev_sel),
    .rd_byte      (glob_rd)
  );

  cfg_gpio_bank #(
    .NUM_PS_GRP (NUM_PS_GRP),
    .NUM_SE_GRP (NUM_SE_GRP),
    .NUM_OE_GRP (NUM_OE_GRP)
  ) u_gpio (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_en     (data_wr && dev_sel && gpio_sel_ldn),
    .cur_idx   (cur_idx),
    .wr_byte   (bus_wdata),
    .rd_byte   (gpio_rd),
    .gpio_base (gpio_base),
    .gpio_pol  (gpio_pol),
    .gpio_sel  (gpio_sel),
    .gpio_oe   (gpio_oe)
  );

  always_comb begin
    if (dev_sel) begin
      reg_rd = gpio_sel_ldn ? gpio_rd : 8'h00;
    end else begin
      reg_rd = glob_rd;
    end
  end

  logic [7:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = 8'hFF;
    if (hit_idx) begin
      rdata_d = cfg_open ? cur_idx : 8'hFF;
    end else if (hit_data) begin
      rdata_d = cfg_open ? reg_rd : 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rdata_q <= 8'hFF;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk
  import cfg_port_pkg::*;
#(
  parameter int OE_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [15:0]     bus_addr,
  input logic [7:0]      bus_wdata,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [7:0]      bus_rdata,
  input logic            cfg_open,
  input logic [15:0]     gpio_base,
  input logic [OE_W-1:0] gpio_oe,
  input logic [7:0]      cur_idx,
  input logic [7:0]      cur_ldn
);

  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(bus_wr && bus_addr == IDX_PORT_ADDR && bus_wdata == KEY_B3));

  a_r4_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !cfg_open && (bus_addr == IDX_PORT_ADDR || bus_addr == DATA_PORT_ADDR))
      |=> bus_rdata == 8'hFF);

  a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !cfg_open && bus_addr == DATA_PORT_ADDR)
      |=> ($stable(gpio_base) && $stable(gpio_oe) && $stable(cur_ldn)));

  a_r5_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r7_other_ldn_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cfg_open && bus_addr == DATA_PORT_ADDR && cur_ldn != LDN_GPIO && cur_idx >= DEV_SPACE)
      |=> ($stable(gpio_base) && $stable(gpio_oe)));

  a_r11_lock_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> $past(bus_wr && bus_addr == DATA_PORT_ADDR && bus_wdata == EXIT_VALUE));

endmodule

bind cfg_port_top cfg_port_chk #(.OE_W(8*NUM_OE_GRP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .cfg_open  (cfg_open),
  .gpio_base (gpio_base),
  .gpio_oe   (gpio_oe),
  .cur_idx   (cur_idx),
  .cur_ldn   (cur_ldn)
);

// File: tb/tb_cfg_port_top.sv
`timescale 1ns/1ps
module tb_cfg_port_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_rdata;
  logic        cfg_open;
  logic [15:0] gpio_base;
  logic [39:0] gpio_pol;
  logic [39:0] gpio_sel;
  logic [63:0] gpio_oe;

  cfg_port_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cfg_open  (cfg_open),
    .gpio_base (gpio_base),
    .gpio_pol  (gpio_pol),
    .gpio_sel  (gpio_sel),
    .gpio_oe   (gpio_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  localparam logic [15:0] IP = 16'h002E;
  localparam logic [15:0] DP = 16'h002F;
  localparam logic W = 1'b0;
  localparam logic R = 1'b1;

  typedef struct packed {
    logic        is_rd;
    logic [15:0] addr;
    logic [7:0]  val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 57;
  localparam vec_t VEC [NV] = '{
    // R4: locked accesses
    '{R, DP, 8'hFF, 4'd4}, '{W, DP, 8'h11, 4'd4}, '{R, IP, 8'hFF, 4'd4},
    // R3: interrupted key, re-seeded by 0x87
    '{W, IP, 8'h87, 4'd3}, '{W, IP, 8'h01, 4'd3}, '{W, IP, 8'h87, 4'd3},
    '{W, IP, 8'h01, 4'd3}, '{W, IP, 8'h55, 4'd3}, '{W, IP, 8'h55, 4'd3},
    // R2: open, index cleared
    '{R, IP, 8'h00, 4'd2},
    // R6: identity and revision
    '{W, IP, 8'h20, 4'd6}, '{R, DP, 8'h87, 4'd6}, '{W, IP, 8'h21, 4'd6},
    '{R, DP, 8'h28, 4'd6}, '{W, IP, 8'h22, 4'd6}, '{R, DP, 8'h03, 4'd6},
    // R10: unimplemented global index
    '{W, IP, 8'h25, 4'd10}, '{W, DP, 8'h5A, 4'd10}, '{R, DP, 8'h00, 4'd10},
    // R1 reset device 0, R7 select GPIO
    '{W, IP, 8'h07, 4'd7}, '{R, DP, 8'h00, 4'd1}, '{W, DP, 8'h07, 4'd7},
    '{R, DP, 8'h07, 4'd7},
    // R8: base address with forced alignment
    '{W, IP, 8'h62, 4'd8}, '{W, DP, 8'hA1, 4'd8}, '{R, DP, 8'hA1, 4'd8},
    '{W, IP, 8'h63, 4'd8}, '{W, DP, 8'h5F, 4'd8}, '{R, DP, 8'h58, 4'd8},
    // R9: control groups
    '{W, IP, 8'hB2, 4'd9}, '{W, DP, 8'h3C, 4'd9}, '{R, DP, 8'h3C, 4'd9},
    '{W, IP, 8'hCF, 4'd9}, '{W, DP, 8'h81, 4'd9}, '{R, DP, 8'h81, 4'd9},
    '{W, IP, 8'hC4, 4'd9}, '{W, DP, 8'h0F, 4'd9}, '{R, DP, 8'h0F, 4'd9},
    // R10 inside GPIO bank, R5 index readback
    '{W, IP, 8'h40, 4'd10}, '{W, DP, 8'h77, 4'd10}, '{R, DP, 8'h00, 4'd10},
    '{R, IP, 8'h40, 4'd5},
    // R7: other device hides the bank
    '{W, IP, 8'h07, 4'd7}, '{W, DP, 8'h03, 4'd7}, '{W, IP, 8'h62, 4'd7},
    '{R, DP, 8'h00, 4'd7}, '{W, DP, 8'hEE, 4'd7}, '{W, IP, 8'h07, 4'd7},
    '{W, DP, 8'h07, 4'd7}, '{W, IP, 8'h62, 4'd7}, '{R, DP, 8'hA1, 4'd7},
    // R11: exit
    '{W, IP, 8'h02, 4'd11}, '{W, DP, 8'h05, 4'd11}, '{R, IP, 8'h02, 4'd11},
    '{W, DP, 8'h02, 4'd11}, '{R, DP, 8'hFF, 4'd11}, '{R, IP, 8'hFF, 4'd11}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send_key();
    bus_write(IP, 8'h87);
    bus_write(IP, 8'h01);
    bus_write(IP, 8'h55);
    bus_write(IP, 8'h55);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
        report();
      end
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; bus_addr = 16'h0; bus_wdata = 8'h0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 locked", 64'(cfg_open), 64'h0);
    check("R1 rdata", 64'(bus_rdata), 64'hFF);
    check("R1 base", 64'(gpio_base), 64'h0);
    check("R1 oe", gpio_oe, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) begin
        bus_read(VEC[i].addr, rd);
        n_checks++;
        if (rd !== VEC[i].val) begin
          n_fail++;
          $display("FAIL R%0d vector %0d: actual %0h expected %0h", VEC[i].req, i, rd, VEC[i].val);
        end
      end else begin
        bus_write(VEC[i].addr, VEC[i].val);
      end
    end

    // R8, R9, R11: pin outputs after the table
    check("R8 gpio_base", 64'(gpio_base), 64'hA158);
    check("R9 pol group 2", 64'(gpio_pol[23:16]), 64'h3C);
    check("R9 oe group 7", 64'(gpio_oe[63:56]), 64'h81);
    check("R9 sel group 4", 64'(gpio_sel[39:32]), 64'h0F);
    check("R9 other oe groups", 64'(gpio_oe[55:0]), 64'h0);
    check("R11 locked", 64'(cfg_open), 64'h0);

    // R3: non-0x87 wrong byte does not unlock
    bus_write(IP, 8'h87);
    bus_write(IP, 8'h01);
    bus_write(IP, 8'h33);
    bus_write(IP, 8'h55);
    bus_write(IP, 8'h55);
    check("R3 bad key stays locked", 64'(cfg_open), 64'h0);

    // R4: locked data write leaves GPIO untouched
    bus_write(DP, 8'h00);
    check("R4 base kept", 64'(gpio_base), 64'hA158);

    // R2: cfg_open rises the cycle after the fourth key byte
    bus_write(IP, 8'h87);
    bus_write(IP, 8'h01);
    bus_write(IP, 8'h55);
    check("R2 not yet open", 64'(cfg_open), 64'h0);
    bus_write(IP, 8'h55);
    check("R2 open", 64'(cfg_open), 64'h1);

    // R5: read latency and hold
    bus_write(IP, 8'h20);
    @(negedge clk);
    bus_addr = DP; bus_rd = 1'b1;
    #1;
    check("R5 old value before edge", 64'(bus_rdata), 64'hFF);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R5 new value after edge", 64'(bus_rdata), 64'h87);
    bus_write(IP, 8'h21);
    repeat (2) @(negedge clk);
    check("R5 hold", 64'(bus_rdata), 64'h87);

    // R6: identity ignores writes
    bus_write(DP, 8'h00);
    bus_read(DP, rd);
    check("R6 id low read-only", 64'(rd), 64'h28);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 relock", 64'(cfg_open), 64'h0);
    check("R1 base cleared", 64'(gpio_base), 64'h0);
    check("R1 pol cleared", 64'(gpio_pol), 64'h0);
    check("R1 rdata", 64'(bus_rdata), 64'hFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_key();
    bus_write(IP, 8'h07);
    bus_read(DP, rd);
    check("R1 device 0 after reset", 64'(rd), 64'h0);

    report();
  end

endmodule